// File: doc/BRIEF.md
# EEPROM Write Master with Acknowledge Polling

This block is a two-wire (I2C) bus master that delivers a short write burst to a serial EEPROM and then, on request, waits for the memory to finish its internal programming cycle. The host presents a 7-bit device address, one to four data bytes and a byte count, and pulses `start`. The block drives the open-drain clock and data lines only through pull-low enables, so an external wired-AND network and pull-ups produce the actual line levels, which come back on `scl_in` and `sda_in`.

A memory that is still programming does not acknowledge its address. The block treats such a missing acknowledge as "device busy", not as a fault. It ends the frame with a STOP so that the clock line is released, then addresses the device again. It repeats this until the device answers or a programmable retry budget runs out, and in the second case it raises `error`. When polling is enabled, a successful write is followed by address-only frames until the device acknowledges. The clock timing comes from a prescaler and from separate low-phase and high-phase counts.

Top module: `i2cw_master`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are low (both lines released), `busy`, `done` and `error` are low, and `retry_cnt` is zero.
- R2: A `start` pulse is taken only while the block is idle and the monitored bus is free (no START seen since the last STOP). A `start` during a transfer has no effect: the bytes delivered and the number of `done` pulses are those of the first transfer alone.
- R3: A write frame is START, then the address byte `{dev_addr, 0}`, then `byte_cnt+1` data bytes taken from `wdata` lane 0 (`wdata[7:0]`) upwards, then STOP. Every byte is sent MSB first, and the ninth clock of each byte samples the acknowledge (SDA low = ACK).
- R4: SDA never changes in the same cycle that SCL is released. SDA changes while SCL is high only to form START (falling) or STOP (rising).
- R5: Every SCL low phase lasts `(psc+1)*max(scl_lo,1)` clock cycles. Every high phase inside a byte lasts `(psc+1)*max(scl_hi,1)` cycles, and a count of zero acts as one.
- R6: When an acknowledge is missing and `retry_cnt` is below the limit, the block stops sending data, issues STOP, increments `retry_cnt` and restarts from the address byte.
- R7: With `poll_en` high, a write that was acknowledged throughout is followed by address-only frames (START, address, ACK sample, STOP) until one is acknowledged. The transfer then ends without error.
- R8: With `poll_en` low, the transfer ends after the STOP of the first fully acknowledged write frame, without any polling frame.
- R9: A missing acknowledge while `retry_cnt` equals `retry_limit` ends the transfer with STOP, `error` high and both lines released. `retry_cnt` then equals `retry_limit`.
- R10: `done` is a single-cycle pulse at the end of each accepted transfer. `busy` is high from acceptance until the final STOP is issued and seen on the bus. `error` and `retry_cnt` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| dev_addr | input | 7 | Device address |
| byte_cnt | input | 2 | Number of data bytes minus one |
| wdata | input | 32 | Data bytes, lane 0 sent first |
| poll_en | input | 1 | Poll for write completion after the write |
| retry_limit | input | 8 | Retries allowed before error |
| psc | input | 8 | Prescaler: one timing tick every psc+1 clocks |
| scl_lo | input | 8 | SCL low phase in ticks (0 acts as 1) |
| scl_hi | input | 8 | SCL high phase in ticks (0 acts as 1) |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| busy | output | 1 | Transfer in progress or bus not yet free |
| done | output | 1 | One-cycle end-of-transfer pulse |
| error | output | 1 | Retry budget exhausted in the last transfer |
| retry_cnt | output | 8 | Retries performed in the last transfer |

## Verification
The properties assume that the device only pulls SDA low during a low phase of SCL and never holds SCL itself. They also assume that `psc`, `scl_lo` and `scl_hi` stay constant while `busy` is high, and that each SCL low-plus-high bit time spans at least three clocks, so that the two-stage input synchronizer delivers the acknowledge before it is sampled. The bench keeps to these assumptions: its EEPROM model changes its pull only at SCL falling edges, it changes timing settings only between transfers, and it chooses prescaler and phase counts whose smallest bit time is four clocks.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,   // lines released, waiting for start
        ST_SU,     // START setup: SCL high, SDA high
        ST_HD,     // START hold: SCL high, SDA low
        ST_BLO,    // bit low phase: SDA set up
        ST_BHI,    // bit high phase: SDA held, ACK sampled at end
        ST_PLO,    // STOP prep: SCL low, SDA low
        ST_PSU,    // STOP setup: SCL high, SDA low
        ST_PBUF    // bus free time after SDA release
    } wr_state_e;

    typedef enum logic {
        PH_WRITE,
        PH_POLL
    } wr_phase_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drv_t;

    // Pull-low enables for each state; tx_low is the current bit inverted.
    function automatic line_drv_t drive_for(wr_state_e st, logic tx_low);
        line_drv_t d;
        d = '0;
        case (st)
            ST_HD:   d.sda_low = 1'b1;
            ST_BLO:  begin d.scl_low = 1'b1; d.sda_low = tx_low; end
            ST_BHI:  d.sda_low = tx_low;
            ST_PLO:  begin d.scl_low = 1'b1; d.sda_low = 1'b1; end
            ST_PSU:  d.sda_low = 1'b1;
            default: d = '0;
        endcase
        return d;
    endfunction

    function automatic logic is_low_phase(wr_state_e st);
        return (st == ST_BLO) || (st == ST_PLO);
    endfunction

endpackage

// File: rtl/i2cw_tick_timer.sv
module i2cw_tick_timer #(
    parameter int PSC_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             use_low,
    input  logic [PSC_W-1:0] psc,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [CNT_W-1:0] hi_cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [PSC_W-1:0] pcnt;
    logic [CNT_W-1:0] ccnt;
    logic [CNT_W-1:0] sel;
    logic [CNT_W-1:0] tgt;
    logic             tick;

    always_comb begin
        sel    = use_low ? lo_cnt : hi_cnt;
        tgt    = (sel == '0) ? ONE : sel;
        tick   = (pcnt == psc);
        expire = run && tick && (ccnt == tgt - ONE);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
            ccnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
            ccnt <= expire ? '0 : ccnt + ONE;
        end else begin
            pcnt <= pcnt + PSC_W'(1);
        end
    end
endmodule

// File: rtl/i2cw_line_mon.sv
module i2cw_line_mon (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic bus_busy
);
    logic [1:0] scl_q;
    logic [1:0] sda_q;
    logic       scl_p;
    logic       sda_p;
    logic       scl_s;
    logic       start_det;
    logic       stop_det;

    always_comb begin
        scl_s     = scl_q[1];
        sda_s     = sda_q[1];
        start_det = scl_s && scl_p && sda_p && !sda_s;
        stop_det  = scl_s && scl_p && !sda_p && sda_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q    <= 2'b11;
            sda_q    <= 2'b11;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            bus_busy <= 1'b0;
        end else begin
            scl_q <= {scl_q[0], scl_in};
            sda_q <= {sda_q[0], sda_in};
            scl_p <= scl_s;
            sda_p <= sda_s;
            if (start_det)     bus_busy <= 1'b1;
            else if (stop_det) bus_busy <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cw_master.sv
module i2cw_master
    import i2cw_pkg::*;
#(
    parameter int MAX_BYTES = 4,
    parameter int PSC_W     = 8,
    parameter int CNT_W     = 8,
    parameter int RTY_W     = 8,
    localparam int IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int BI_W     = $clog2(MAX_BYTES + 1),
    localparam int DATA_W   = 8 * MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [6:0]        dev_addr,
    input  logic [IDX_W-1:0]  byte_cnt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              poll_en,
    input  logic [RTY_W-1:0]  retry_limit,
    input  logic [PSC_W-1:0]  psc,
    input  logic [CNT_W-1:0]  scl_lo,
    input  logic [CNT_W-1:0]  scl_hi,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [RTY_W-1:0]  retry_cnt
);
    wr_state_e         st;
    wr_phase_e         ph;
    logic [3:0]        nb;
    logic [BI_W-1:0]   bi;
    logic [7:0]        sh;
    logic              nack_q;
    logic [RTY_W-1:0]  rty_q;
    logic [RTY_W-1:0]  lim_q;
    logic              err_q;
    logic              done_q;
    logic [6:0]        addr_q;
    logic [IDX_W-1:0]  cnt_q;
    logic [DATA_W-1:0] data_q;
    logic              poll_q;

    logic              expire;
    logic              sda_s;
    logic              bus_busy;
    logic              last_byte;
    logic              active;
    line_drv_t         drv;
    logic [7:0]        lanes [MAX_BYTES];

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
        assign lanes[g] = data_q[8*g +: 8];
    end

    i2cw_tick_timer #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (active),
        .use_low (is_low_phase(st)),
        .psc     (psc),
        .lo_cnt  (scl_lo),
        .hi_cnt  (scl_hi),
        .expire  (expire)
    );

    i2cw_line_mon u_mon (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_s    (sda_s),
        .bus_busy (bus_busy)
    );

    always_comb begin
        active    = (st != ST_IDLE);
        last_byte = (bi == BI_W'(cnt_q) + BI_W'(1));
        drv       = drive_for(st, (nb != 4'd8) && !sh[7]);
        scl_oe    = drv.scl_low;
        sda_oe    = drv.sda_low;
        busy      = active || bus_busy;
        done      = done_q;
        error     = err_q;
        retry_cnt = rty_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            ph     <= PH_WRITE;
            nb     <= '0;
            bi     <= '0;
            sh     <= '0;
            nack_q <= 1'b0;
            rty_q  <= '0;
            lim_q  <= '0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
            addr_q <= '0;
            cnt_q  <= '0;
            data_q <= '0;
            poll_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: if (start && !bus_busy) begin
                    addr_q <= dev_addr;
                    cnt_q  <= byte_cnt;
                    data_q <= wdata;
                    poll_q <= poll_en;
                    lim_q  <= retry_limit;
                    rty_q  <= '0;
                    err_q  <= 1'b0;
                    ph     <= PH_WRITE;
                    st     <= ST_SU;
                end
                ST_SU: if (expire) st <= ST_HD;
                ST_HD: if (expire) begin
                    sh     <= {addr_q, 1'b0};
                    nb     <= '0;
                    bi     <= '0;
                    nack_q <= 1'b0;
                    st     <= ST_BLO;
                end
                ST_BLO: if (expire) st <= ST_BHI;
                ST_BHI: if (expire) begin
                    if (nb != 4'd8) begin
                        sh <= {sh[6:0], 1'b0};
                        nb <= nb + 4'd1;
                        st <= ST_BLO;
                    end else if (sda_s) begin
                        nack_q <= 1'b1;
                        st     <= ST_PLO;
                    end else if (ph == PH_POLL || last_byte) begin
                        st <= ST_PLO;
                    end else begin
                        sh <= lanes[bi[IDX_W-1:0]];
                        bi <= bi + BI_W'(1);
                        nb <= '0;
                        st <= ST_BLO;
                    end
                end
                ST_PLO: if (expire) st <= ST_PSU;
                ST_PSU: if (expire) st <= ST_PBUF;
                ST_PBUF: if (expire) begin
                    if (nack_q) begin
                        if (rty_q == lim_q) begin
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end else begin
                            rty_q <= rty_q + RTY_W'(1);
                            st    <= ST_SU;
                        end
                    end else if (ph == PH_WRITE && poll_q) begin
                        ph <= PH_POLL;
                        st <= ST_SU;
                    end else begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
    parameter int RTY_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic [RTY_W-1:0] retry_cnt,
    input logic [RTY_W-1:0] lim
);
    p_sda_stable_on_release_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_oe) |-> $stable(sda_oe));

    p_retry_bound_r6: assert property (@(posedge clk) disable iff (rst)
        retry_cnt <= lim);

    p_err_at_limit_r9: assert property (@(posedge clk) disable iff (rst)
        (done && error) |-> (retry_cnt == lim));

    p_err_rises_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> done);

    p_lines_free_at_end_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!scl_oe && !sda_oe));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    p_err_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> $stable(error));
endmodule

bind i2cw_master i2cw_checker #(.RTY_W(RTY_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .retry_cnt (retry_cnt),
    .lim       (lim_q)
);

// File: tb/tb_i2cw_master.sv
module tb_i2cw_master;
    localparam logic [6:0] MADDR = 7'h50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  dev_addr = MADDR;
    logic [1:0]  byte_cnt = '0;
    logic [31:0] wdata = '0;
    logic        poll_en = 1'b0;
    logic [7:0]  retry_limit = '0;
    logic [7:0]  psc = 8'd1;
    logic [7:0]  scl_lo = 8'd2;
    logic [7:0]  scl_hi = 8'd2;
    logic        scl_oe, sda_oe, busy, done, error;
    logic [7:0]  retry_cnt;
    logic        m_pull = 1'b0;

    wire scl_line = ~scl_oe;
    wire sda_line = ~(sda_oe | m_pull);

    always #2.5 clk = ~clk;

    i2cw_master dut (
        .clk(clk), .rst(rst), .start(start), .dev_addr(dev_addr),
        .byte_cnt(byte_cnt), .wdata(wdata), .poll_en(poll_en),
        .retry_limit(retry_limit), .psc(psc), .scl_lo(scl_lo), .scl_hi(scl_hi),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .done(done), .error(error), .retry_cnt(retry_cnt)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // EEPROM model state
    int         cfg_k = 0;
    int         busy_left = 0;
    int         got_n = 0;
    logic [7:0] got [4];
    logic [7:0] m_fb [4];
    logic [7:0] m_sh = '0;
    logic [7:0] last_addr = '0;
    int         m_bit = 0, m_nb = 0;
    bit         m_in = 0, m_ok = 0;
    logic       m_pscl = 1'b1, m_psda = 1'b1;
    int         bad_edges = 0;
    int         done_cnt = 0;
    // timing monitor
    logic       t_prev = 1'b1;
    bit         t_rose = 0;
    int         t_run = 1;
    int         lo_min = 9999, lo_max = 0, hi_min = 9999;

    always @(negedge clk) begin
        logic sc, sd;
        sc = scl_line;
        sd = sda_line;
        if (rst) begin
            m_pull = 1'b0; m_in = 0; m_ok = 0;
        end else begin
            if (done) done_cnt++;
            if (m_pscl && sc && m_psda && !sd) begin
                m_in = 1; m_ok = 0; m_bit = 0; m_nb = 0;
            end else if (m_pscl && sc && !m_psda && sd) begin
                if (m_ok && m_nb > 1) begin
                    for (int i = 0; i < m_nb - 1 && i < 4; i++) got[i] = m_fb[i];
                    got_n = m_nb - 1;
                    busy_left = cfg_k;
                end
                m_in = 0; m_ok = 0; m_pull = 1'b0;
            end else if (!m_pscl && sc) begin
                if (m_psda != sd) bad_edges++;
                if (m_in && m_bit < 8) begin
                    m_sh = {m_sh[6:0], sd};
                    m_bit++;
                end
            end else if (m_pscl && !sc) begin
                if (m_in && m_bit == 8) begin
                    if (m_nb == 0) begin
                        last_addr = m_sh;
                        if (m_sh[7:1] == MADDR && !m_sh[0] && busy_left == 0) begin
                            m_pull = 1'b1; m_ok = 1;
                        end else begin
                            if (m_sh[7:1] == MADDR && busy_left > 0) busy_left--;
                            m_in = 0;
                        end
                    end else begin
                        if (m_nb <= 4) m_fb[m_nb-1] = m_sh;
                        m_pull = 1'b1;
                    end
                    m_bit = 9;
                end else if (m_bit == 9) begin
                    m_pull = 1'b0; m_bit = 0; m_nb++;
                end
            end
        end
        m_pscl = sc;
        m_psda = sd;
        // SCL phase widths
        if (!rst) begin
            if (scl_line == t_prev) t_run++;
            else begin
                if (!t_prev) begin
                    if (t_run < lo_min) lo_min = t_run;
                    if (t_run > lo_max) lo_max = t_run;
                end else if (t_rose && t_run < hi_min) hi_min = t_run;
                t_rose = scl_line;
                t_run = 1;
            end
            t_prev = scl_line;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_rty(int k, int lim);
        return (k > lim) ? lim : k;
    endfunction

    function automatic bit exp_err(int k, int lim);
        return k > lim;
    endfunction

    task automatic launch(input logic [6:0] a, input logic [1:0] c, input logic [31:0] d,
                          input logic p, input logic [7:0] lim, input int k, input bit clr);
        while (busy) step();
        cfg_k = k;
        if (clr) busy_left = 0;
        got_n = 0;
        for (int i = 0; i < 4; i++) got[i] = 8'h00;
        done_cnt = 0; bad_edges = 0;
        lo_min = 9999; lo_max = 0; hi_min = 9999;
        dev_addr = a; byte_cnt = c; wdata = d; poll_en = p; retry_limit = lim;
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic finish_xfer();
        step();
        while (busy) step();
        repeat (3) step();
    endtask

    task automatic check_bytes(input string req, input logic [1:0] c, input logic [31:0] d);
        chk(req, "byte count", got_n, c + 1);
        for (int i = 0; i <= int'(c); i++) chk(req, "data byte", got[i], d[8*i +: 8]);
    endtask

    task automatic check_timing(input string req);
        int lo_e, hi_e;
        lo_e = (psc + 1) * ((scl_lo == 0) ? 1 : scl_lo);
        hi_e = (psc + 1) * ((scl_hi == 0) ? 1 : scl_hi);
        chk(req, "low min", lo_min, lo_e);
        chk(req, "low max", lo_max, lo_e);
        chk(req, "high min", hi_min, hi_e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [1:0]  c;
        int          k, lim;
        void'($urandom(32'd2718));
        repeat (4) step();
        // R1: reset values
        chk("R1", "scl_oe", scl_oe, 0);
        chk("R1", "sda_oe", sda_oe, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "error", error, 0);
        chk("R1", "retry_cnt", retry_cnt, 0);
        rst = 1'b0;
        repeat (4) step();

        // R3 R7: four bytes, polling through 3 busy answers
        launch(MADDR, 2'd3, 32'hC3A5_1E87, 1'b1, 8'd10, 3, 1);
        finish_xfer();
        check_bytes("R3", 2'd3, 32'hC3A5_1E87);
        chk("R3", "address byte", last_addr, {MADDR, 1'b0});
        chk("R7", "retry_cnt", retry_cnt, 3);
        chk("R7", "error", error, 0);
        chk("R10", "done pulses", done_cnt, 1);
        chk("R4", "sda edge at scl release", bad_edges, 0);
        check_timing("R5");

        // R7: one byte, device ready at first poll
        launch(MADDR, 2'd0, 32'h0000_005A, 1'b1, 8'd4, 0, 1);
        finish_xfer();
        check_bytes("R3", 2'd0, 32'h0000_005A);
        chk("R7", "retry_cnt", retry_cnt, 0);
        chk("R7", "error", error, 0);

        // R9: budget exhausted during polling
        launch(MADDR, 2'd1, 32'h0000_BEEF, 1'b1, 8'd2, 5, 1);
        finish_xfer();
        chk("R9", "error", error, 1);
        chk("R9", "retry_cnt", retry_cnt, 2);
        chk("R9", "scl released", scl_oe, 0);
        chk("R9", "sda released", sda_oe, 0);
        chk("R10", "done pulses", done_cnt, 1);
        repeat (20) step();
        chk("R10", "error held", error, 1);
        chk("R10", "retry_cnt held", retry_cnt, 2);

        // R8 R6: no polling; next write meets a busy device
        launch(MADDR, 2'd1, 32'h0000_1234, 1'b0, 8'd6, 2, 1);
        finish_xfer();
        check_bytes("R8", 2'd1, 32'h0000_1234);
        chk("R8", "retry_cnt", retry_cnt, 0);
        launch(MADDR, 2'd2, 32'h0077_8899, 1'b0, 8'd6, 0, 0);
        finish_xfer();
        check_bytes("R6", 2'd2, 32'h0077_8899);
        chk("R6", "retry_cnt", retry_cnt, 2);
        chk("R6", "error", error, 0);

        // R9: absent device, limit zero
        launch(7'h21, 2'd0, 32'h11, 1'b1, 8'd0, 0, 1);
        finish_xfer();
        chk("R9", "error absent", error, 1);
        chk("R9", "retry absent", retry_cnt, 0);
        chk("R9", "no bytes", got_n, 0);

        // R5: zero counts clamp to one
        psc = 8'd3; scl_lo = 8'd0; scl_hi = 8'd0;
        launch(MADDR, 2'd0, 32'h3C, 1'b0, 8'd1, 0, 1);
        finish_xfer();
        check_timing("R5");
        check_bytes("R5", 2'd0, 32'h3C);

        // R2: start during a transfer is ignored
        psc = 8'd1; scl_lo = 8'd3; scl_hi = 8'd2;
        launch(MADDR, 2'd1, 32'h0000_6655, 1'b0, 8'd3, 0, 1);
        repeat (40) step();
        wdata = 32'hFFFF_0000; byte_cnt = 2'd3; start = 1'b1;
        step();
        start = 1'b0;
        finish_xfer();
        repeat (20) step();
        chk("R2", "busy after", busy, 0);
        chk("R2", "done pulses", done_cnt, 1);
        check_bytes("R2", 2'd1, 32'h0000_6655);
        check_timing("R5");

        // random transfers against computed expectations
        for (int n = 0; n < 8; n++) begin
            d   = $urandom();
            c   = 2'($urandom() % 4);
            k   = int'($urandom() % 5);
            lim = int'($urandom() % 5);
            psc = 8'(1 + $urandom() % 2);
            scl_lo = 8'($urandom() % 4);
            scl_hi = 8'($urandom() % 4);
            launch(MADDR, c, d, 1'b1, 8'(lim), k, 1);
            finish_xfer();
            check_bytes("R3", c, d);
            chk("R6", "retry_cnt", retry_cnt, exp_rty(k, lim));
            chk("R9", "error", error, exp_err(k, lim));
            chk("R4", "sda edge at scl release", bad_edges, 0);
            chk("R10", "done pulses", done_cnt, 1);
            check_timing("R5");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule